// File: doc/BRIEF.md
# Rotated Immediate Constant Encoder

This block takes a 32-bit constant and searches for a 12-bit immediate field that reproduces it: an 8-bit value and a 4-bit rotate count. The decoded constant is the value zero-extended and rotated right by twice the count. When the constant has no such form, the block tries its bitwise inverse. If that succeeds, it sets an invert flag so that a move-not form can be used. If both forms fail, the block reports the constant as not representable.

The search is sequential and tests one rotation per cycle, counts 0 to 15 in order, first on the plain constant and then on the inverse. A start pulse begins a search, and a one-cycle done pulse presents the result. A combinational decoder is included, so that a field and an invert flag can be expanded back into a 32-bit constant.

Top module: `rot_imm_encoder`

## Requirements
- R1: The result field puts the rotate count in bits [11:8] and the value in bits [7:0]. The decoder output equals the value zero-extended and rotated right by 2×count, bitwise inverted when the decoder's invert input is 1. Decoding any produced result returns the input constant.
- R2: Every constant from 0 to 255 encodes with count 0, value equal to the constant, and invert 0.
- R3: When more than one count fits, the smallest is reported. For example, 0x10 gives count 0, 0x3FC gives count 15 with value 0xFF, and 0xAB000000 gives count 4 with value 0xAB.
- R4: Every single-bit constant and every constant with one nonzero byte at a byte-aligned position encodes without inversion.
- R5: The inverse is tried only when the plain constant fails. A success on the inverse sets invert. 0xFFFFFFFE gives value 1, count 0, invert 1.
- R6: A constant that fails in both forms, such as 0xABCDEF11, sets the not-representable flag with field 0 and invert 0.
- R7: Take the start edge as cycle 0. done pulses high for exactly one cycle, at edge r+1 for a plain hit at count r, at edge 17+r for an inverted hit, and at edge 32 for a failure.
- R8: busy is high from the start edge until the done edge, and never together with done. A start while busy is ignored.
- R9: The field and both flags hold their values until the next done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a search when idle |
| const_i | input | 32 | Constant to encode, sampled with start |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle result strobe |
| field_o | output | 12 | Rotate count [11:8], value [7:0] |
| inv_o | output | 1 | Field encodes the inverted constant |
| nrep_o | output | 1 | Constant not representable |
| dec_field_i | input | 12 | Field to decode |
| dec_inv_i | input | 1 | Invert the decoded constant |
| dec_value_o | output | 32 | Decoded constant |

## Verification
The assertions assume that start is only ever raised as a single-cycle pulse, with const_i stable at the sampling edge. They also assume that reset is asserted at time zero. The bench drives start for exactly one cycle from a point away from the clock edge, and holds reset low for the opening cycles. It also raises start once in the middle of a search, to check that the request is ignored. Its constants cover small values, single bits, aligned bytes, multi-fit values, inverse-only values and constants that fail in both forms.

// File: rtl/rot_imm_pkg.sv
package rot_imm_pkg;
  localparam int DATA_W = 32;
  localparam int IMM_W  = 8;
  localparam int ROT_W  = 4;
  localparam int FIELD_W = IMM_W + ROT_W;

  function automatic logic [DATA_W-1:0] rotr_fn(logic [DATA_W-1:0] x, int unsigned s);
    logic [2*DATA_W-1:0] d;
    d = {x, x} >> s;
    return d[DATA_W-1:0];
  endfunction
endpackage

// File: rtl/rot_fit.sv
module rot_fit #(
  parameter int DATA_W = rot_imm_pkg::DATA_W,
  parameter int IMM_W  = rot_imm_pkg::IMM_W,
  parameter int ROT_W  = rot_imm_pkg::ROT_W
) (
  input  logic [DATA_W-1:0] cand_i,
  input  logic [ROT_W-1:0]  rot_i,
  output logic              fit_o,
  output logic [IMM_W-1:0]  imm_o
);
  localparam int NUM_ROT  = 1 << ROT_W;
  localparam int ROT_STEP = DATA_W / NUM_ROT;
  localparam int SH_W     = $clog2(DATA_W);

  logic [SH_W-1:0]     shamt;
  logic [2*DATA_W-1:0] dbl;
  logic [DATA_W-1:0]   rotl;

  // left-rotate undoes the decoder's right-rotate
  assign shamt = SH_W'(32'(rot_i) * ROT_STEP);
  assign dbl   = {cand_i, cand_i} << shamt;
  assign rotl  = dbl[2*DATA_W-1:DATA_W];
  assign fit_o = (rotl[DATA_W-1:IMM_W] == '0);
  assign imm_o = rotl[IMM_W-1:0];
endmodule

// File: rtl/imm_decoder.sv
module imm_decoder #(
  parameter int DATA_W = rot_imm_pkg::DATA_W,
  parameter int IMM_W  = rot_imm_pkg::IMM_W,
  parameter int ROT_W  = rot_imm_pkg::ROT_W
) (
  input  logic [IMM_W+ROT_W-1:0] field_i,
  input  logic                   inv_i,
  output logic [DATA_W-1:0]      value_o
);
  localparam int NUM_ROT  = 1 << ROT_W;
  localparam int ROT_STEP = DATA_W / NUM_ROT;
  localparam int SH_W     = $clog2(DATA_W);

  logic [SH_W-1:0]     shamt;
  logic [2*DATA_W-1:0] dbl;
  logic [DATA_W-1:0]   plain;

  assign shamt   = SH_W'(32'(field_i[IMM_W+:ROT_W]) * ROT_STEP);
  assign dbl     = {{(DATA_W-IMM_W){1'b0}}, field_i[IMM_W-1:0],
                    {(DATA_W-IMM_W){1'b0}}, field_i[IMM_W-1:0]} >> shamt;
  assign plain   = dbl[DATA_W-1:0];
  assign value_o = inv_i ? ~plain : plain;
endmodule

// File: rtl/rot_search.sv
module rot_search #(
  parameter int DATA_W = rot_imm_pkg::DATA_W,
  parameter int IMM_W  = rot_imm_pkg::IMM_W,
  parameter int ROT_W  = rot_imm_pkg::ROT_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic [DATA_W-1:0]      const_i,
  output logic                   busy_o,
  output logic                   done_o,
  output logic [IMM_W+ROT_W-1:0] field_o,
  output logic                   inv_o,
  output logic                   nrep_o
);
  localparam int FIELD_W  = IMM_W + ROT_W;
  localparam int ROT_STEP = DATA_W / (1 << ROT_W);

  typedef enum logic {S_IDLE, S_SEARCH} state_e;

  state_e             state_q;
  logic [DATA_W-1:0]  val_q;
  logic [ROT_W-1:0]   rot_q;
  logic               pass_inv_q;
  logic [DATA_W-1:0]  cand;
  logic               fit;
  logic [IMM_W-1:0]   imm;

  assign cand = pass_inv_q ? ~val_q : val_q;

  rot_fit #(.DATA_W(DATA_W), .IMM_W(IMM_W), .ROT_W(ROT_W)) u_fit (
    .cand_i(cand), .rot_i(rot_q), .fit_o(fit), .imm_o(imm)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      val_q      <= '0;
      rot_q      <= '0;
      pass_inv_q <= 1'b0;
      done_o     <= 1'b0;
      field_o    <= '0;
      inv_o      <= 1'b0;
      nrep_o     <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        S_IDLE: if (start_i) begin
          val_q      <= const_i;
          rot_q      <= '0;
          pass_inv_q <= 1'b0;
          state_q    <= S_SEARCH;
        end
        S_SEARCH: begin
          if (fit) begin
            field_o <= {rot_q, imm};
            inv_o   <= pass_inv_q;
            nrep_o  <= 1'b0;
            done_o  <= 1'b1;
            state_q <= S_IDLE;
          end else if (rot_q == '1) begin
            if (pass_inv_q) begin
              field_o <= '0;
              inv_o   <= 1'b0;
              nrep_o  <= 1'b1;
              done_o  <= 1'b1;
              state_q <= S_IDLE;
            end else begin
              pass_inv_q <= 1'b1;
              rot_q      <= '0;
            end
          end else begin
            rot_q <= rot_q + 1'b1;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q == S_SEARCH);

  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_busy_done_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));
  p_ignore_start_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i |=> $stable(val_q));
  p_roundtrip_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !nrep_o |->
      (rot_imm_pkg::rotr_fn(DATA_W'(field_o[IMM_W-1:0]),
         32'(field_o[FIELD_W-1:IMM_W]) * ROT_STEP) == (inv_o ? ~val_q : val_q)));
  p_nrep_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && nrep_o |-> field_o == '0 && !inv_o);
  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(field_o) && $stable(inv_o) && $stable(nrep_o));
endmodule

// File: rtl/rot_imm_encoder.sv
module rot_imm_encoder #(
  parameter int DATA_W = rot_imm_pkg::DATA_W,
  parameter int IMM_W  = rot_imm_pkg::IMM_W,
  parameter int ROT_W  = rot_imm_pkg::ROT_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic [DATA_W-1:0]      const_i,
  output logic                   busy_o,
  output logic                   done_o,
  output logic [IMM_W+ROT_W-1:0] field_o,
  output logic                   inv_o,
  output logic                   nrep_o,
  input  logic [IMM_W+ROT_W-1:0] dec_field_i,
  input  logic                   dec_inv_i,
  output logic [DATA_W-1:0]      dec_value_o
);
  rot_search #(.DATA_W(DATA_W), .IMM_W(IMM_W), .ROT_W(ROT_W)) u_search (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .const_i(const_i),
    .busy_o(busy_o), .done_o(done_o), .field_o(field_o),
    .inv_o(inv_o), .nrep_o(nrep_o)
  );

  imm_decoder #(.DATA_W(DATA_W), .IMM_W(IMM_W), .ROT_W(ROT_W)) u_dec (
    .field_i(dec_field_i), .inv_i(dec_inv_i), .value_o(dec_value_o)
  );
endmodule

// File: tb/rot_imm_encoder_bench.sv
module rot_imm_encoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] cval = '0;
  logic        busy, done, inv, nrep;
  logic [11:0] field;
  logic [11:0] dfield = '0;
  logic        dinv = 1'b0;
  logic [31:0] dval;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  rot_imm_encoder u_rot_imm_encoder (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .const_i(cval),
    .busy_o(busy), .done_o(done), .field_o(field), .inv_o(inv), .nrep_o(nrep),
    .dec_field_i(dfield), .dec_inv_i(dinv), .dec_value_o(dval)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rl(logic [31:0] x, int s);
    if (s == 0) return x;
    return (x << s) | (x >> (32 - s));
  endfunction

  // reference: search order and latency per requirements
  task automatic ref_enc(input logic [31:0] v, output logic [11:0] f,
                         output logic iv, output logic nr, output int lat);
    f = '0; iv = 0; nr = 1; lat = 32;
    for (int p = 0; p < 2; p++) begin
      for (int r = 0; r < 16; r++) begin
        logic [31:0] t;
        t = rl(p ? ~v : v, 2 * r);
        if (nr && t < 256) begin
          f = {r[3:0], t[7:0]}; iv = p[0]; nr = 0; lat = 16 * p + r + 1;
        end
      end
    end
  endtask

  task automatic run(string req, logic [31:0] v, bit poke = 0);
    logic [11:0] ef; logic ei, en; int lat;
    ref_enc(v, ef, ei, en, lat);
    @(negedge clk);
    cval = v; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0; cval = 32'h1234_5678;
    for (int c = 0; c <= lat; c++) begin
      if (c > 0) begin @(posedge clk); #1; end
      if (poke && c == 3) start = 1'b1;
      if (poke && c == 4) start = 1'b0;
      if (c < lat) begin
        chk("R8", busy, 1, "busy during search");
        chk("R7", done, 0, "done early");
      end else begin
        chk("R7", done, 1, "done at expected edge");
        chk("R8", busy, 0, "busy at done");
        chk(req, field, ef, "field");
        chk(req, inv, ei, "invert flag");
        chk(req, nrep, en, "not-representable flag");
      end
    end
    dfield = field; dinv = inv; #1;
    if (!en) chk("R1", dval, v, "decoded round trip");
    @(posedge clk); #1;
    chk("R7", done, 0, "done one cycle only");
    chk("R9", field, ef, "field held");
    chk("R9", {inv, nrep}, {ei, en}, "flags held");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R9", {busy, done, inv, nrep}, 0, "reset flags");
    chk("R9", field, 0, "reset field");
    rst_n = 1'b1;
    // R2 small values
    run("R2", 32'h0); run("R2", 32'h7F); run("R2", 32'hFF);
    // R3 smallest count
    run("R3", 32'h10); run("R3", 32'h3FC); run("R3", 32'hAB00_0000);
    run("R3", 32'h0003_F000); run("R3", 32'h0000_0FF0);
    // R4 single bits and aligned bytes
    for (int b = 0; b < 32; b++) run("R4", 32'h1 << b);
    for (int k = 0; k < 4; k++) run("R4", 32'hC5 << (8 * k));
    // R5 inverse fallback
    run("R5", 32'hFFFF_FFFE); run("R5", 32'hFFFF_FFFF); run("R5", 32'hFFFF_FF00);
    run("R5", 32'h54FF_FFFF);
    // R6 neither form
    run("R6", 32'hABCD_EF11); run("R6", 32'h0000_0101);
    // R8 start while busy ignored
    run("R8", 32'hFFFF_FFFE, 1);
    // R1 decoder alone: count 1 value 0x03 rotates right by 2
    dfield = 12'h103; dinv = 1'b0; #1;
    chk("R1", dval, 32'hC000_0000, "decoder rotate");
    dinv = 1'b1; #1;
    chk("R1", dval, 32'h3FFF_FFFF, "decoder invert");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule